// File: doc/BRIEF.md
# Linked Call and Interrupt-Return Sequencer

This block carries out the control-transfer half of three instruction kinds: a subroutine call that leaves a return link in memory, a conditional branch, and a conditional return from an interrupt service routine. A decoder hands it one operation at a time with the effective address, the address of the following instruction and the verdict of the condition evaluator. The block then drives a memory write port and the instruction-counter load port, and holds itself busy for a fixed number of cycles that stands for the instruction's execution time. A taken operation uses a long slot. A conditional form that is not taken uses a short one.

The block also owns the interrupt level state. Incoming requests are latched as pending bits. Levels in service are held as an active bit vector, where a higher bit index means a higher priority. A pending level is accepted only when it outranks every active level, the sequencer is idle and the one-instruction interrupt lockout is clear. A taken interrupt return releases the highest active level. Every call, and every taken interrupt return, arms the lockout. The lockout is lifted by the next completed instruction, whether that instruction is reported from outside or is another operation of this block.

Top module: `cr_link_ctrl`

## Requirements
- R1: Operation code 0 (unconditional call) writes `next_ic` to address `ea` in the first cycle of its slot. It loads the counter with `ea + 1` and pulses `done` in the last cycle. The slot is T_TAKE cycles (default 20), and `cond_hit` has no effect on it.
- R2: Operation code 1 (conditional call) with `cond_hit` low behaves as R1. With `cond_hit` high it writes nothing, loads nothing and pulses `done` after T_SKIP cycles (default 11).
- R3: Operation codes 2 (conditional branch) and 3 (interrupt return) are taken when `cond_hit` is low. A taken one loads the counter with `ea` and pulses `done` in cycle T_TAKE. One that is not taken loads nothing and pulses `done` in cycle T_SKIP. Neither writes memory.
- R4: A call's memory write and its counter load occur in different cycles, with the write first.
- R5: `inh` rises in the cycle after `done` of any call, whether taken or not, and after `done` of a taken interrupt return. It does not rise after a branch or after a return that is not taken.
- R6: While `inh` is high, the first completed instruction clears it in the following cycle. A completed instruction is either a pulse on `instr_end` or a `done` of this block that does not set `inh` again.
- R7: A taken interrupt return pulses `lvl_clr` in its `done` cycle, with `lvl_clr_idx` set to the highest active level, and that level leaves `active_lvls` one cycle later. A return that is not taken leaves `active_lvls` unchanged.
- R8: A request bit is latched as pending. It is accepted, as an `irq_take` pulse with `irq_take_lvl` and a new bit in `active_lvls` one cycle later, only when it outranks all active levels, `inh` is low and the sequencer is idle with no `start`.
- R9: A request at a level equal to or lower than the highest active level stays pending and is accepted once the blocking levels are cleared and `inh` is low.
- R10: A `start` that arrives while `busy` is high is ignored.
- R11: After reset, `busy`, `inh`, `mem_we`, `ic_ld`, `lvl_clr`, `irq_take` and `active_lvls` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 2 | Operation: 0 call, 1 conditional call, 2 branch, 3 interrupt return |
| ea | input | AW | Effective address |
| next_ic | input | AW | Address of the following instruction |
| cond_hit | input | 1 | Evaluator verdict: at least one tested condition holds |
| instr_end | input | 1 | Pulse: an instruction completed elsewhere |
| irq_req | input | NLVL | Interrupt request per level |
| busy | output | 1 | Operation slot in progress |
| done | output | 1 | Last cycle of the slot |
| mem_we | output | 1 | Link write strobe |
| mem_addr | output | AW | Link write address |
| mem_wdata | output | AW | Link write data |
| ic_ld | output | 1 | Instruction counter load strobe |
| ic_val | output | AW | Instruction counter load value |
| inh | output | 1 | One-instruction interrupt lockout |
| irq_take | output | 1 | Interrupt level accepted |
| irq_take_lvl | output | LW | Accepted level |
| active_lvls | output | NLVL | Levels in service |
| lvl_clr | output | 1 | Highest active level released |
| lvl_clr_idx | output | LW | Released level |

## Verification
The assertions assume that `op`, `ea`, `next_ic` and `cond_hit` are valid in the cycle `start` is high. They also assume that `instr_end` is never asserted in the same cycle as a `done` that arms the lockout, so that a completion is never reported twice. The stimulus holds operand inputs only around a `start`, pulses `instr_end` only while the block is idle, and raises interrupt requests only between operations. Under these conditions, the rule that a level is accepted and released one level at a time holds exactly, so the active-count steps in the assertions are valid.

// File: rtl/cr_pkg.sv
// Package: shared operation encoding for the call/return sequencer.
// Assumes: op codes are decoded upstream into these four values.
package cr_pkg;
    typedef enum logic [1:0] {
        OP_CALL  = 2'd0,
        OP_CCALL = 2'd1,
        OP_BR    = 2'd2,
        OP_RETI  = 2'd3
    } cr_op_e;
endpackage

// File: rtl/cr_prio_enc.sv
// Module: finds the highest set bit of a vector.
// Assumes: N >= 2; idx is zero when no bit is set (valid low).
module cr_prio_enc #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         valid,
    output logic [W-1:0] idx
);
    // scan upward so the highest set index wins
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                valid = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/cr_seq.sv
// Module: operation sequencer. It latches one operation, times its slot,
// issues the link write in the first cycle and the counter load in the last.
// Assumes: T_TAKE >= 2 so write and load fall in distinct cycles; T_SKIP >= 1.
module cr_seq
    import cr_pkg::*;
#(
    parameter int AW     = 16,
    parameter int T_TAKE = 20,
    parameter int T_SKIP = 11,
    localparam int CW    = $clog2(T_TAKE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  cr_op_e        op,
    input  logic [AW-1:0] ea,
    input  logic [AW-1:0] next_ic,
    input  logic          cond_hit,
    output logic          busy,
    output logic          done,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    output logic          ic_ld,
    output logic [AW-1:0] ic_val,
    output logic          set_inh,
    output logic          clr_req
);
    logic          busy_q;
    logic [CW-1:0] cnt_q;
    cr_op_e        op_q;
    logic [AW-1:0] ea_q;
    logic [AW-1:0] nic_q;
    logic          taken_q;
    logic          wr_pend_q;
    logic          taken_in;
    logic          is_call_in;
    logic          is_call_q;

    // taken decision: unconditional call always, conditional forms on no hit
    assign taken_in   = (op == OP_CALL) || !cond_hit;
    assign is_call_in = (op == OP_CALL) || (op == OP_CCALL);
    assign is_call_q  = (op_q == OP_CALL) || (op_q == OP_CCALL);

    // slot state: latch operands at start, count down to the last cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            op_q      <= OP_CALL;
            ea_q      <= '0;
            nic_q     <= '0;
            taken_q   <= 1'b0;
            wr_pend_q <= 1'b0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q    <= 1'b1;
                cnt_q     <= taken_in ? CW'(T_TAKE - 1) : CW'(T_SKIP - 1);
                op_q      <= op;
                ea_q      <= ea;
                nic_q     <= next_ic;
                taken_q   <= taken_in;
                wr_pend_q <= taken_in && is_call_in;
            end
        end else begin
            wr_pend_q <= 1'b0;
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - CW'(1);
        end
    end

    // outputs decoded from slot state
    assign busy      = busy_q;
    assign done      = busy_q && (cnt_q == '0);
    assign mem_we    = busy_q && wr_pend_q;
    assign mem_addr  = ea_q;
    assign mem_wdata = nic_q;
    assign ic_ld     = done && taken_q;
    assign ic_val    = is_call_q ? (ea_q + AW'(1)) : ea_q;
    assign set_inh   = done && (is_call_q || ((op_q == OP_RETI) && taken_q));
    assign clr_req   = done && (op_q == OP_RETI) && taken_q;

    // R4: the link write never shares a cycle with the counter load
    a_r4_write_apart: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !ic_ld);
    // R1: after a counter load the slot is over
    a_r1_load_ends_slot: assert property (@(posedge clk) disable iff (!rst_n)
        ic_ld |=> !busy);
    // R10: a running slot stays busy until its last cycle
    a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    // R10: operands stay frozen while busy
    a_r10_operands_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(ea_q) && $stable(nic_q));
endmodule

// File: rtl/cr_irq_levels.sv
// Module: interrupt level state: pending latch, active vector, lockout.
// Assumes: clr_req and idle_ok are never high together (release happens
// at the end of a busy slot, acceptance only when idle).
module cr_irq_levels #(
    parameter int NLVL = 8,
    localparam int LW  = $clog2(NLVL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] irq_req,
    input  logic            idle_ok,
    input  logic            set_inh,
    input  logic            instr_end,
    input  logic            own_end,
    input  logic            clr_req,
    output logic            inh,
    output logic [NLVL-1:0] active,
    output logic            irq_take,
    output logic [LW-1:0]   take_lvl,
    output logic            lvl_clr,
    output logic [LW-1:0]   lvl_clr_idx
);
    logic [NLVL-1:0] pend_q;
    logic [NLVL-1:0] act_q;
    logic            inh_q;
    logic            p_valid;
    logic [LW-1:0]   p_idx;
    logic            a_valid;
    logic [LW-1:0]   a_idx;
    logic [NLVL-1:0] take_hot;
    logic [NLVL-1:0] clr_hot;

    cr_prio_enc #(.N(NLVL)) u_pend_enc (.vec(pend_q), .valid(p_valid), .idx(p_idx));
    cr_prio_enc #(.N(NLVL)) u_act_enc  (.vec(act_q),  .valid(a_valid), .idx(a_idx));

    // acceptance: idle, no lockout, and strictly above every active level
    assign irq_take    = idle_ok && !inh_q && p_valid && (!a_valid || (p_idx > a_idx));
    assign take_lvl    = p_idx;
    assign lvl_clr     = clr_req && a_valid;
    assign lvl_clr_idx = a_idx;

    // per-level one-hot masks for acceptance and release
    for (genvar g = 0; g < NLVL; g++) begin : g_mask
        assign take_hot[g] = irq_take && (p_idx == LW'(g));
        assign clr_hot[g]  = lvl_clr  && (a_idx == LW'(g));
    end

    // pending and active level registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            pend_q <= (pend_q | irq_req) & ~take_hot;
            act_q  <= (act_q & ~clr_hot) | take_hot;
        end
    end

    // one-instruction lockout: armed by the sequencer, lifted by a completion
    always_ff @(posedge clk) begin
        if (!rst_n)                     inh_q <= 1'b0;
        else if (set_inh)               inh_q <= 1'b1;
        else if (instr_end || own_end)  inh_q <= 1'b0;
    end

    assign inh    = inh_q;
    assign active = act_q;

    // R8: an acceptance adds exactly one active level
    a_r8_take_adds_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> $countones(active) == $past($countones(active)) + 1);
    // R7: a release removes exactly one active level
    a_r7_clr_drops_level: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_clr |=> $countones(active) == $past($countones(active)) - 1);
    // R5: arming is seen in the next cycle
    a_r5_inh_armed: assert property (@(posedge clk) disable iff (!rst_n)
        set_inh |=> inh);
    // R6: a completion while locked out lifts the lockout
    a_r6_inh_lifted: assert property (@(posedge clk) disable iff (!rst_n)
        (inh && !set_inh && (instr_end || own_end)) |=> !inh);
    // R7: without a release or acceptance the active set is unchanged
    a_r7_active_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_clr && !irq_take) |=> $stable(active));
endmodule

// File: rtl/cr_link_ctrl.sv
// Module: top of the linked call and interrupt-return sequencer.
// Joins the slot sequencer with the interrupt level state.
// Assumes: operand inputs valid with start; instr_end not coincident with done.
module cr_link_ctrl
    import cr_pkg::*;
#(
    parameter int AW     = 16,
    parameter int NLVL   = 8,
    parameter int T_TAKE = 20,
    parameter int T_SKIP = 11,
    localparam int LW    = $clog2(NLVL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic [AW-1:0]   ea,
    input  logic [AW-1:0]   next_ic,
    input  logic            cond_hit,
    input  logic            instr_end,
    input  logic [NLVL-1:0] irq_req,
    output logic            busy,
    output logic            done,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [AW-1:0]   mem_wdata,
    output logic            ic_ld,
    output logic [AW-1:0]   ic_val,
    output logic            inh,
    output logic            irq_take,
    output logic [LW-1:0]   irq_take_lvl,
    output logic [NLVL-1:0] active_lvls,
    output logic            lvl_clr,
    output logic [LW-1:0]   lvl_clr_idx
);
    cr_op_e op_e;
    logic   set_inh;
    logic   clr_req;
    logic   idle_ok;

    // operation code cast into the shared encoding
    assign op_e    = cr_op_e'(op);
    assign idle_ok = !busy && !start;

    cr_seq #(.AW(AW), .T_TAKE(T_TAKE), .T_SKIP(T_SKIP)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (op_e),
        .ea        (ea),
        .next_ic   (next_ic),
        .cond_hit  (cond_hit),
        .busy      (busy),
        .done      (done),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ic_ld     (ic_ld),
        .ic_val    (ic_val),
        .set_inh   (set_inh),
        .clr_req   (clr_req)
    );

    cr_irq_levels #(.NLVL(NLVL)) u_lvl (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req     (irq_req),
        .idle_ok     (idle_ok),
        .set_inh     (set_inh),
        .instr_end   (instr_end),
        .own_end     (done),
        .clr_req     (clr_req),
        .inh         (inh),
        .active      (active_lvls),
        .irq_take    (irq_take),
        .take_lvl    (irq_take_lvl),
        .lvl_clr     (lvl_clr),
        .lvl_clr_idx (lvl_clr_idx)
    );

    // R8: no acceptance while a slot runs
    a_r8_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq_take);
    // R7: a release only ever happens in a done cycle
    a_r7_clr_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_clr |-> done && ic_ld);
endmodule

// File: tb/cr_link_ctrl_tb.sv
// Bench: scoreboard. Driver tasks queue expected events with their cycle,
// a monitor pops and compares each observed event.
module cr_link_ctrl_tb;
    localparam int CLK_P  = 10;
    localparam int AW     = 16;
    localparam int NLVL   = 8;
    localparam int LW     = 3;
    localparam int T_TAKE = 20;
    localparam int T_SKIP = 11;
    localparam int K_WR = 0, K_LD = 1, K_CLR = 2, K_TAKE = 3, K_DONE = 4;

    typedef struct {
        int    cyc;
        int    kind;
        int    a;
        int    d;
        string req;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [1:0]      op = 2'd0;
    logic [AW-1:0]   ea = '0;
    logic [AW-1:0]   next_ic = '0;
    logic            cond_hit = 1'b0;
    logic            instr_end = 1'b0;
    logic [NLVL-1:0] irq_req = '0;
    logic            busy, done, mem_we, ic_ld, inh, irq_take, lvl_clr;
    logic [AW-1:0]   mem_addr, mem_wdata, ic_val;
    logic [LW-1:0]   irq_take_lvl, lvl_clr_idx;
    logic [NLVL-1:0] active_lvls;

    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   finished = 0;
    exp_t q[$];

    cr_link_ctrl #(.AW(AW), .NLVL(NLVL), .T_TAKE(T_TAKE), .T_SKIP(T_SKIP)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .ea(ea),
        .next_ic(next_ic), .cond_hit(cond_hit), .instr_end(instr_end),
        .irq_req(irq_req), .busy(busy), .done(done), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ic_ld(ic_ld),
        .ic_val(ic_val), .inh(inh), .irq_take(irq_take),
        .irq_take_lvl(irq_take_lvl), .active_lvls(active_lvls),
        .lvl_clr(lvl_clr), .lvl_clr_idx(lvl_clr_idx)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic push(int c, int kind, int a, int d, string req);
        exp_t e;
        e.cyc = c; e.kind = kind; e.a = a; e.d = d; e.req = req;
        q.push_back(e);
    endtask

    // compare one observed event with the head of the queue
    task automatic sb_take(int kind, int a, int d);
        exp_t e;
        if (q.size() == 0) begin
            check(1'b0, "unexpected event", kind, -1);
            return;
        end
        e = q.pop_front();
        check(e.kind == kind, e.req, kind, e.kind);
        check(e.cyc == cyc, e.req, cyc, e.cyc);
        check(e.a == a, e.req, a, e.a);
        check(e.d == d, e.req, d, e.d);
    endtask

    // monitor: sample well after the negedge drive and before the next posedge
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (rst_n) begin
            while (q.size() > 0 && q[0].cyc < cyc) begin
                check(1'b0, q[0].req, -1, q[0].kind);
                void'(q.pop_front());
            end
            if (mem_we)   sb_take(K_WR, int'(mem_addr), int'(mem_wdata));
            if (ic_ld)    sb_take(K_LD, int'(ic_val), 0);
            if (lvl_clr)  sb_take(K_CLR, int'(lvl_clr_idx), 0);
            if (irq_take) sb_take(K_TAKE, int'(irq_take_lvl), 0);
            if (done)     sb_take(K_DONE, 0, 0);
        end
    end

    // driver: issue one operation, queue its expected events, wait past done
    task automatic do_op(int o, int a, int nic, bit hit);
        int  c0;
        bit  taken;
        bit  call;
        int  len;
        @(negedge clk);
        start = 1'b1; op = 2'(o); ea = AW'(a); next_ic = AW'(nic); cond_hit = hit;
        c0    = cyc + 1;
        taken = (o == 0) || !hit;
        call  = (o == 0) || (o == 1);
        len   = taken ? T_TAKE : T_SKIP;
        if (taken && call) push(c0, K_WR, a, nic, "R1/R2 link write");
        if (taken) push(c0 + len - 1, K_LD, call ? ((a + 1) & 16'hFFFF) : a, 0, "R1/R3 counter load");
        if (taken && o == 3) push(c0 + len - 1, K_CLR, -2, 0, "R7 level clear");
        push(c0 + len - 1, K_DONE, 0, 0, "R2/R3 slot length");
        @(negedge clk);
        start = 1'b0;
        repeat (len) @(negedge clk);
    endtask

    // fix up a queued clear expectation with the level it must release
    task automatic set_clr_lvl(int lvl);
        foreach (q[i]) if (q[i].kind == K_CLR && q[i].a == -2) q[i].a = lvl;
    endtask

    task automatic pulse_end();
        @(negedge clk);
        instr_end = 1'b1;
        @(negedge clk);
        instr_end = 1'b0;
    endtask

    task automatic raise_req(int lvl, bit expect_take);
        @(negedge clk);
        irq_req = NLVL'(1) << lvl;
        if (expect_take) push(cyc + 1, K_TAKE, lvl, 0, "R8 acceptance");
        @(negedge clk);
        irq_req = '0;
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: reset state
        check(!busy && !inh && !mem_we && !ic_ld && !lvl_clr && !irq_take,
              "R11 reset outputs", {busy, inh, mem_we, ic_ld, lvl_clr, irq_take}, 0);
        check(active_lvls == 0, "R11 reset active", active_lvls, 0);

        // R1: unconditional call ignores cond_hit
        do_op(0, 'h0A00, 'h0301, 1'b1);
        #1 check(inh == 1'b1, "R5 inh after call", inh, 1);
        pulse_end();
        #1 check(inh == 1'b0, "R6 inh cleared by instr_end", inh, 0);

        // R2: conditional call not taken still arms the lockout
        do_op(1, 'h0200, 'h0105, 1'b1);
        #1 check(inh == 1'b1, "R5 inh after untaken call", inh, 1);
        // R6: own branch completion lifts it, R5: untaken branch does not arm
        do_op(2, 'h0300, 'h0106, 1'b1);
        #1 check(inh == 1'b0, "R6 inh cleared by own completion", inh, 0);

        // R2: conditional call taken, with address wrap on ea+1
        do_op(1, 'hFFFF, 'h1234, 1'b0);
        pulse_end();
        #1 check(inh == 1'b0, "R6 inh cleared", inh, 0);

        // R3: taken branch, R5: no lockout
        do_op(2, 'h4444, 'h0001, 1'b0);
        #1 check(inh == 1'b0, "R5 no inh after branch", inh, 0);

        // R10: start while busy is ignored
        begin
            int c0;
            @(negedge clk);
            start = 1'b1; op = 2'd2; ea = 16'h1234; cond_hit = 1'b0;
            c0 = cyc + 1;
            push(c0 + T_TAKE - 1, K_LD, 'h1234, 0, "R10 load of first op");
            push(c0 + T_TAKE - 1, K_DONE, 0, 0, "R10 only one done");
            @(negedge clk);
            start = 1'b0;
            repeat (4) @(negedge clk);
            start = 1'b1; op = 2'd0; ea = 16'h5555; next_ic = 16'h6666;
            @(negedge clk);
            start = 1'b0;
            repeat (T_TAKE) @(negedge clk);
            #1 check(busy == 1'b0, "R10 idle after single slot", busy, 0);
        end

        // R8: accept level 2
        raise_req(2, 1'b1);
        #1 check(active_lvls == 8'h04, "R8 level 2 active", active_lvls, 8'h04);
        // R9: lower level 1 held pending
        raise_req(1, 1'b0);
        repeat (2) @(negedge clk);
        #1 check(active_lvls == 8'h04, "R9 level 1 not accepted", active_lvls, 8'h04);
        // R8: higher level 3 nests
        raise_req(3, 1'b1);
        #1 check(active_lvls == 8'h0C, "R8 level 3 nested", active_lvls, 8'h0C);

        // R7: return not taken keeps levels
        do_op(3, 'h0700, 'h0701, 1'b1);
        #1 check(active_lvls == 8'h0C, "R7 untaken return keeps levels", active_lvls, 8'h0C);
        check(inh == 1'b0, "R5 no inh after untaken return", inh, 0);

        // R7: taken return releases level 3
        fork
            do_op(3, 'h0800, 'h0801, 1'b0);
            begin #(CLK_P); set_clr_lvl(3); end
        join
        #1 check(active_lvls == 8'h04, "R7 level 3 released", active_lvls, 8'h04);
        check(inh == 1'b1, "R5 inh after taken return", inh, 1);
        pulse_end();
        repeat (2) @(negedge clk);
        #1 check(active_lvls == 8'h04, "R9 level 1 still blocked by 2", active_lvls, 8'h04);

        // R7/R9: release level 2; level 1 waits for the lockout to lift
        fork
            do_op(3, 'h0900, 'h0901, 1'b0);
            begin #(CLK_P); set_clr_lvl(2); end
        join
        repeat (2) @(negedge clk);
        #1 check(active_lvls == 8'h00, "R9 lockout blocks level 1", active_lvls, 8'h00);
        @(negedge clk);
        instr_end = 1'b1;
        push(cyc + 1, K_TAKE, 1, 0, "R9 pending level 1 accepted");
        @(negedge clk);
        instr_end = 1'b0;
        @(negedge clk);
        #1 check(active_lvls == 8'h02, "R9 level 1 active", active_lvls, 8'h02);

        repeat (3) @(negedge clk);
        #(CLK_P/2);
        check(q.size() == 0, "scoreboard drained", q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule